// File: doc/BRIEF.md
# Processor-Idle Cache Sleep Controller

This controller decides when the peripheral circuitry of a second-level cache can be put into a low-leakage sleep state. Sleep is allowed only while the core is stalled behind an outstanding cache miss. The controller watches three per-cycle inputs: a flag that says a miss is pending, a flag that says an instruction was issued, and a flag that says a functional unit did work. Once the core has shown no issue and no execute activity for `IDLE_K` consecutive cycles, the controller raises the sleep output.

An external estimator supplies the number of cycles left until the miss data returns. The controller drops sleep as soon as that count reaches the wake margin `WAKE_M`. This margin is a parameter and must be at least the peripherals' wakeup latency `WAKE_LAT`, so the returning data never waits. A ready output models the wakeup latency and rises `WAKE_LAT` cycles after sleep is released.

If a cache access request arrives while the cache is asleep, the cache is woken at once and a sticky violation flag is set. That flag exists for verification.

Top module: `l2_idle_sleep_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `sleep_o` is 0, `periph_ready_o` is 1 and `violation_o` is 0.
- R2: A cycle counts as idle when `miss_pending_i`=1, `issued_i`=0, `fu_active_i`=0 and `cache_req_i`=0. `sleep_o` rises at the clock edge that samples the `IDLE_K`-th consecutive idle cycle (default 10), and not one edge earlier.
- R3: Any cycle with `issued_i`, `fu_active_i` or `cache_req_i` high resets the idle run to zero. After such a cycle, a new full run of `IDLE_K` idle cycles is needed before sleep.
- R4: With `miss_pending_i`=0 the controller never asserts sleep, however long the core is inactive.
- R5: Sleep is entered only if `cycles_to_return_i` is strictly greater than `WAKE_M` at the entry edge. A threshold that is reached with the count at or below `WAKE_M` leaves the cache awake.
- R6: While asleep, `sleep_o` falls at the first edge that samples `cycles_to_return_i` <= `WAKE_M`. It also falls at the first edge that samples `miss_pending_i`=0.
- R7: `periph_ready_o` is 0 while `sleep_o` is 1. It returns to 1 exactly `WAKE_LAT` cycles after `sleep_o` falls, and it is 1 when the miss data returns (`cycles_to_return_i` = 0).
- R8: A `cache_req_i` sampled while asleep clears `sleep_o` at that edge and sets `violation_o`. `violation_o` stays 1 until reset.
- R9: While asleep, issue or functional-unit activity alone does not wake the cache.
- R10: A `cache_req_i` in the cycle that would otherwise complete the idle run prevents sleep entry and does not set `violation_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_pending_i | input | 1 | A second-level cache miss is outstanding |
| issued_i | input | 1 | An instruction was issued this cycle |
| fu_active_i | input | 1 | A functional unit executed this cycle |
| cache_req_i | input | 1 | Access request to the cache this cycle |
| cycles_to_return_i | input | RET_W | Cycles remaining until the miss data returns |
| sleep_o | output | 1 | Sleep control for the cache peripherals |
| periph_ready_o | output | 1 | Peripherals are fully awake |
| violation_o | output | 1 | Sticky: an access arrived while asleep |

## Verification
Two of the controller's functions can fall in the same cycle: completing the idle threshold and receiving an access request. The bench provokes this by raising `cache_req_i` exactly on the `IDLE_K`-th idle cycle. It expects sleep to stay low and the violation flag to stay clear, and it then expects a fresh full run before sleep is entered. A second pairing is an access request arriving while asleep, which takes priority over the scheduled wake. The bench judges this by the falling sleep edge together with the flag, which stays set across later cycles.

// File: rtl/l2slp_pkg.sv
// Package: shared types for the processor-idle cache sleep controller.
// Assumes nothing beyond IEEE 1800-2017.
package l2slp_pkg;

    // Power state of the cache peripherals.
    typedef enum logic [0:0] {
        PWR_AWAKE  = 1'b0,
        PWR_ASLEEP = 1'b1
    } pwr_state_e;

endpackage

// File: rtl/l2slp_idle_run.sv
// Module: l2slp_idle_run
// Counts consecutive fully idle cycles (miss pending, no issue, no
// execute, no cache request) and flags the cycle that completes the
// K-th one. The count saturates at K.
// Assumes IDLE_K >= 1.
module l2slp_idle_run #(
    parameter int IDLE_K = 10,
    parameter int RUN_W  = $clog2(IDLE_K + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic miss_pending_i,
    input  logic issued_i,
    input  logic fu_active_i,
    input  logic cache_req_i,
    output logic threshold_hit_o
);

    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(IDLE_K);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(IDLE_K - 1);

    logic             idle_now;
    logic [RUN_W-1:0] run_q;

    // Decide whether the current cycle counts toward the idle run.
    always_comb begin
        idle_now = miss_pending_i & ~issued_i & ~fu_active_i & ~cache_req_i;
    end

    // Advance the run on an idle cycle, clear it on any activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!idle_now) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Flag the edge at which the run reaches (or stays at) the threshold.
    always_comb begin
        threshold_hit_o = idle_now && (run_q >= RUN_LAST);
    end

endmodule

// File: rtl/l2slp_sleep_fsm.sv
// Module: l2slp_sleep_fsm
// Two-state power controller. It enters sleep when the idle threshold
// is met with enough return margin. It leaves sleep on a low margin, on
// the end of the miss, or on an access request; an access request also
// sets a sticky violation flag.
// Assumes the return count is supplied by an external estimator.
module l2slp_sleep_fsm
    import l2slp_pkg::*;
#(
    parameter int WAKE_M = 8,
    parameter int RET_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             threshold_hit_i,
    input  logic             miss_pending_i,
    input  logic             cache_req_i,
    input  logic [RET_W-1:0] cycles_to_return_i,
    output logic             sleep_o,
    output logic             violation_o
);

    localparam logic [RET_W-1:0] MARGIN = RET_W'(WAKE_M);

    pwr_state_e state_q, state_d;
    logic       margin_ok;
    logic       viol_q;

    // Check whether the remaining return time exceeds the wake margin.
    always_comb begin
        margin_ok = cycles_to_return_i > MARGIN;
    end

    // Compute the next power state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_AWAKE: begin
                if (threshold_hit_i && margin_ok) state_d = PWR_ASLEEP;
            end
            PWR_ASLEEP: begin
                if (cache_req_i || !miss_pending_i || !margin_ok) state_d = PWR_AWAKE;
            end
            default: state_d = PWR_AWAKE;
        endcase
    end

    // Hold the power state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PWR_AWAKE;
        else        state_q <= state_d;
    end

    // Latch any access that found the cache asleep.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   viol_q <= 1'b0;
        else if (state_q == PWR_ASLEEP && cache_req_i) viol_q <= 1'b1;
    end

    // Drive outputs from registered state.
    always_comb begin
        sleep_o     = (state_q == PWR_ASLEEP);
        violation_o = viol_q;
    end

endmodule

// File: rtl/l2slp_wake_timer.sv
// Module: l2slp_wake_timer
// Models peripheral wakeup latency: ready is low while asleep and for
// WAKE_LAT cycles after sleep falls.
// Assumes WAKE_LAT >= 1.
module l2slp_wake_timer #(
    parameter int WAKE_LAT = 4,
    parameter int LAT_W    = $clog2(WAKE_LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    output logic ready_o
);

    logic [LAT_W-1:0] wait_q;

    // Reload while asleep, count down after release.
    always_ff @(posedge clk) begin
        if (!rst_n)             wait_q <= '0;
        else if (sleep_i)       wait_q <= LAT_W'(WAKE_LAT);
        else if (wait_q != '0)  wait_q <= wait_q - 1'b1;
    end

    // Report ready once awake and the latency has elapsed.
    always_comb begin
        ready_o = !sleep_i && (wait_q == '0);
    end

endmodule

// File: rtl/l2_idle_sleep_ctrl.sv
// Module: l2_idle_sleep_ctrl (top)
// Sleeps cache peripherals while the core is idle behind an outstanding
// miss, and wakes them WAKE_M cycles before the miss data returns.
// Assumes WAKE_M >= WAKE_LAT and that cycles_to_return_i counts down
// by one per cycle while a miss is pending.
module l2_idle_sleep_ctrl #(
    parameter int IDLE_K   = 10,
    parameter int WAKE_M   = 8,
    parameter int WAKE_LAT = 4,
    parameter int RET_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_pending_i,
    input  logic             issued_i,
    input  logic             fu_active_i,
    input  logic             cache_req_i,
    input  logic [RET_W-1:0] cycles_to_return_i,
    output logic             sleep_o,
    output logic             periph_ready_o,
    output logic             violation_o
);

    localparam int RUN_W = $clog2(IDLE_K + 1);
    localparam int LAT_W = $clog2(WAKE_LAT + 1);

    logic threshold_hit;

    l2slp_idle_run #(
        .IDLE_K (IDLE_K),
        .RUN_W  (RUN_W)
    ) u_idle_run (
        .clk             (clk),
        .rst_n           (rst_n),
        .miss_pending_i  (miss_pending_i),
        .issued_i        (issued_i),
        .fu_active_i     (fu_active_i),
        .cache_req_i     (cache_req_i),
        .threshold_hit_o (threshold_hit)
    );

    l2slp_sleep_fsm #(
        .WAKE_M (WAKE_M),
        .RET_W  (RET_W)
    ) u_sleep_fsm (
        .clk                (clk),
        .rst_n              (rst_n),
        .threshold_hit_i    (threshold_hit),
        .miss_pending_i     (miss_pending_i),
        .cache_req_i        (cache_req_i),
        .cycles_to_return_i (cycles_to_return_i),
        .sleep_o            (sleep_o),
        .violation_o        (violation_o)
    );

    l2slp_wake_timer #(
        .WAKE_LAT (WAKE_LAT),
        .LAT_W    (LAT_W)
    ) u_wake_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep_o),
        .ready_o (periph_ready_o)
    );

endmodule

// File: rtl/l2_idle_sleep_ctrl_chk.sv
// Module: l2_idle_sleep_ctrl_chk
// Property checker bound to the top; it observes ports only and keeps
// its own idle-run counter for the threshold window.
module l2_idle_sleep_ctrl_chk #(
    parameter int IDLE_K = 10,
    parameter int WAKE_M = 8,
    parameter int RET_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_pending_i,
    input logic             issued_i,
    input logic             fu_active_i,
    input logic             cache_req_i,
    input logic [RET_W-1:0] cycles_to_return_i,
    input logic             sleep_o,
    input logic             periph_ready_o,
    input logic             violation_o
);

    localparam int CW = $clog2(IDLE_K + 1);
    logic [CW-1:0] chk_run;

    // Independent count of consecutive idle cycles, saturating at K.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_run <= '0;
        else if (!(miss_pending_i && !issued_i && !fu_active_i && !cache_req_i)) chk_run <= '0;
        else if (chk_run != CW'(IDLE_K)) chk_run <= chk_run + 1'b1;
    end

    assert_entry_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> chk_run >= CW'(IDLE_K));

    assert_entry_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> $past(!issued_i && !fu_active_i));

    assert_entry_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> $past(miss_pending_i));

    assert_entry_margin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> $past(cycles_to_return_i) > RET_W'(WAKE_M));

    assert_timely_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && cycles_to_return_i <= RET_W'(WAKE_M)) |=> !sleep_o);

    assert_not_ready_asleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> !periph_ready_o);

    assert_req_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && cache_req_i) |=> (!sleep_o && violation_o));

    assert_violation_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        violation_o |=> violation_o);

    assert_activity_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && !cache_req_i && miss_pending_i && cycles_to_return_i > RET_W'(WAKE_M)) |=> sleep_o);

endmodule

bind l2_idle_sleep_ctrl l2_idle_sleep_ctrl_chk #(
    .IDLE_K (IDLE_K),
    .WAKE_M (WAKE_M),
    .RET_W  (RET_W)
) u_chk (.*);

// File: tb/l2_idle_sleep_ctrl_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module l2_idle_sleep_ctrl_tb;

    localparam int K   = 10;
    localparam int M   = 8;
    localparam int LAT = 4;
    localparam int RW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss = 1'b0;
    logic          iss = 1'b0;
    logic          fu = 1'b0;
    logic          req = 1'b0;
    logic [RW-1:0] ret = '0;
    logic          sleep, ready, viol;
    logic          counting = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    l2_idle_sleep_ctrl #(.IDLE_K(K), .WAKE_M(M), .WAKE_LAT(LAT), .RET_W(RW)) u_dut (
        .clk                (clk),
        .rst_n              (rst_n),
        .miss_pending_i     (miss),
        .issued_i           (iss),
        .fu_active_i        (fu),
        .cache_req_i        (req),
        .cycles_to_return_i (ret),
        .sleep_o            (sleep),
        .periph_ready_o     (ready),
        .violation_o        (viol)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // One clock edge; outputs are sampled 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
        if (counting && ret != '0) ret = ret - 1'b1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; miss = 0; iss = 0; fu = 0; req = 0; ret = '0; counting = 0;
        ticks(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        tick();
        chk("R1 sleep", sleep, 1'b0);
        chk("R1 ready", ready, 1'b1);
        chk("R1 violation", viol, 1'b0);
    endtask

    task automatic t_full_cycle();
        do_reset();
        miss = 1; ret = 60; counting = 1;
        ticks(K - 1);
        chk("R2 no sleep at K-1", sleep, 1'b0);
        tick();
        chk("R2 sleep at K", sleep, 1'b1);
        chk("R7 not ready asleep", ready, 1'b0);
        while (ret > RW'(M)) tick();
        chk("R6 still asleep at M+1", sleep, 1'b1);
        tick();
        chk("R6 wake at M", sleep, 1'b0);
        chk("R7 not ready just after wake", ready, 1'b0);
        ticks(LAT - 1);
        chk("R7 not ready at LAT-1", ready, 1'b0);
        tick();
        chk("R7 ready at LAT", ready, 1'b1);
        while (ret != '0) tick();
        chk("R7 ready at return", ready, 1'b1);
        chk("R8 no violation", viol, 1'b0);
    endtask

    task automatic t_activity_resets(input int kind);
        do_reset();
        miss = 1; ret = 200;
        ticks(K - 1);
        if (kind == 0) iss = 1; else if (kind == 1) fu = 1; else req = 1;
        tick();
        iss = 0; fu = 0; req = 0;
        ticks(K - 1);
        chk("R3 run restarted", sleep, 1'b0);
        tick();
        chk("R3 sleep after fresh run", sleep, 1'b1);
        chk("R3 no violation", viol, 1'b0);
    endtask

    task automatic t_no_miss();
        do_reset();
        miss = 0; ret = 200;
        ticks(2 * K);
        chk("R4 no sleep without miss", sleep, 1'b0);
    endtask

    task automatic t_margin();
        do_reset();
        miss = 1; ret = RW'(M);
        ticks(2 * K);
        chk("R5 no sleep at margin M", sleep, 1'b0);
        do_reset();
        miss = 1; ret = RW'(M + 1);
        ticks(K);
        chk("R5 sleep at margin M+1", sleep, 1'b1);
    endtask

    task automatic t_miss_end();
        do_reset();
        miss = 1; ret = 200;
        ticks(K);
        chk("R6 asleep", sleep, 1'b1);
        miss = 0;
        tick();
        chk("R6 wake on miss end", sleep, 1'b0);
    endtask

    task automatic t_activity_and_req_asleep();
        do_reset();
        miss = 1; ret = 200;
        ticks(K);
        iss = 1; fu = 1;
        ticks(3);
        chk("R9 activity ignored", sleep, 1'b1);
        iss = 0; fu = 0; req = 1;
        tick();
        req = 0;
        chk("R8 wake on request", sleep, 1'b0);
        chk("R8 violation set", viol, 1'b1);
        ticks(3);
        chk("R8 violation sticky", viol, 1'b1);
    endtask

    task automatic t_req_at_threshold();
        do_reset();
        miss = 1; ret = 200;
        ticks(K - 1);
        req = 1;
        tick();
        req = 0;
        chk("R10 no sleep on request at K", sleep, 1'b0);
        chk("R10 no violation", viol, 1'b0);
        ticks(K - 1);
        chk("R10 fresh run needed", sleep, 1'b0);
        tick();
        chk("R10 sleep after fresh run", sleep, 1'b1);
    endtask

    initial begin
        #(20 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_full_cycle();
        t_activity_resets(0);
        t_activity_resets(1);
        t_activity_resets(2);
        t_no_miss();
        t_margin();
        t_miss_end();
        t_activity_and_req_asleep();
        t_req_at_threshold();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule